// File: doc/BRIEF.md
# FIFO Threshold Offset Register File

This block holds the two thresholds used by a FIFO's flag logic: the distance from empty at which the almost-empty flag is raised, and the distance from full at which the almost-full flag is raised. Each threshold is kept as a low part and a high part in 9-bit registers, which gives four registers in all. They are loaded through the FIFO's own data input on the write clock and read back through the data output path on the read clock. There is no address. One strobe pin, shared with the second write enable, selects offset access. A write-side pointer and a read-side pointer each step through the registers in a fixed rotation.

What the shared pin does is decided while reset is held. If the pin is low during reset, it acts as the load strobe afterwards, and the first write enable is the only write enable. If the pin is high during reset, it acts as a second write enable, and the offset registers cannot be accessed. The block also decodes the ordinary FIFO write and read strobes from the same pins. It presents the assembled threshold values to the flag comparators. Its own register widths follow the FIFO depth parameter.

Top module: `flag_offset_regs`

## Requirements
- R1: While `rst_n` is low, on every `wr_clk` edge the low registers are set to 7, the high registers are set to 0, and both pointers return to the first register. On every `rd_clk` edge while `rst_n` is low, `rb_data` is set to 0 and `rb_valid` is set to 0. Once reset is released, `empty_ofs` and `full_ofs` both read 7.
- R2: `ld_mode` takes the inverse of `wen2_ld` as sampled on each `wr_clk` edge while `rst_n` is low. It holds that value after reset.
- R3: In load mode, a `wr_clk` edge with `wen2_ld`=0 and `wen1_n`=0 stores `din` into the register selected by the write pointer. The pointer then advances through this order and wraps: 0 empty-low, 1 empty-high, 2 full-low, 3 full-high.
- R4: With `wen2_ld`=0 and `wen1_n`=1, no register changes and the write pointer holds.
- R5: In load mode, an `rd_clk` edge with `wen2_ld`=0 and both read enables low does three things. It loads the register selected by the read pointer into `rb_data`. It sets `rb_valid` high for that one cycle. It advances the read pointer in the R3 order. This pointer is independent of the write pointer.
- R6: With `wen2_ld`=0 and either read enable high, `rb_data` and the read pointer hold, and `rb_valid` is 0.
- R7: At the default depth of 1024, only bits 7:0 of a low register and bits 1:0 of a high register are stored. Every other bit is dropped on write and reads back as 0.
- R8: `empty_ofs` is {empty-high[1:0], empty-low[7:0]} and `full_ofs` is {full-high[1:0], full-low[7:0]}. Both are 10 bits wide at depth 1024, and both follow a register write on the next cycle.
- R9: `fifo_wr` = `rst_n` & !`wen1_n` & `wen2_ld`, in either mode. `fifo_rd` = `rst_n` & !`ren1_n` & !`ren2_n` & (!`ld_mode` | `wen2_ld`). Both are combinational.
- R10: With `ld_mode`=0, no input pattern writes or reads an offset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| wen1_n | input | 1 | First write enable, active low |
| wen2_ld | input | 1 | Second write enable, or active-low load strobe in load mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| din | input | 9 | Data input, used as offset load data |
| ld_mode | output | 1 | 1 when offset access was selected at reset |
| fifo_wr | output | 1 | Decoded ordinary FIFO write strobe |
| fifo_rd | output | 1 | Decoded ordinary FIFO read strobe |
| rb_data | output | 9 | Readback register contents |
| rb_valid | output | 1 | High for the cycle after an offset readback |
| empty_ofs | output | 10 | Assembled almost-empty threshold |
| full_ofs | output | 10 | Assembled almost-full threshold |

## Verification
A single strobe level can fall on an offset access and an ordinary FIFO transfer in the same cycle. With the load pin low, a read enable decodes to a readback. With the load pin high, the same read enable decodes to a FIFO read. The bench switches the load pin cycle by cycle during both write and read traffic. A behavioural model predicts which of the two paths fires on each clock, and the two are judged together. A write-pointer step in one domain and a readback in the other are also interleaved, to show that the two pointers never disturb each other.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_t;

  localparam int NUM_REGS = 4;
  localparam int LO_SPAN  = 8;

  // threshold width: pointer width, with a floor of 9 above 64 words
  function automatic int ofs_width(input int depth);
    int w;
    w = $clog2(depth);
    if (depth > 64 && w < 9) w = 9;
    return w;
  endfunction

  function automatic int lo_bits(input int depth);
    return (ofs_width(depth) < LO_SPAN) ? ofs_width(depth) : LO_SPAN;
  endfunction

  function automatic int hi_bits(input int depth);
    return (ofs_width(depth) > LO_SPAN) ? ofs_width(depth) - LO_SPAN : 0;
  endfunction

  // mask of the bits a register actually keeps
  function automatic int reg_mask(input int depth, input int idx);
    int n;
    n = (idx % 2 == 0) ? lo_bits(depth) : hi_bits(depth);
    return (1 << n) - 1;
  endfunction

  function automatic int reg_init(input int depth, input int idx);
    return (idx % 2 == 0) ? (7 & reg_mask(depth, idx)) : 0;
  endfunction

  // join high and low registers into one threshold
  function automatic int join_ofs(input int lo, input int hi);
    return (hi << LO_SPAN) | lo;
  endfunction

endpackage

// File: rtl/ofs_access_decode.sv
module ofs_access_decode (
  input  logic wr_clk,
  input  logic rst_n,
  input  logic wen1_n,
  input  logic wen2_ld,
  input  logic ren1_n,
  input  logic ren2_n,
  output logic ld_mode,
  output logic ofs_wr_evt,
  output logic ofs_rd_evt,
  output logic fifo_wr,
  output logic fifo_rd
);
  logic mode_q;

  // pin function is captured only while reset is held
  always_ff @(posedge wr_clk) begin
    if (!rst_n) mode_q <= ~wen2_ld;
  end

  assign ld_mode    = mode_q;
  assign ofs_wr_evt = rst_n & mode_q & ~wen2_ld & ~wen1_n;
  assign ofs_rd_evt = rst_n & mode_q & ~wen2_ld & ~ren1_n & ~ren2_n;
  assign fifo_wr    = rst_n & ~wen1_n & wen2_ld;
  assign fifo_rd    = rst_n & ~ren1_n & ~ren2_n & (~mode_q | wen2_ld);
endmodule

// File: rtl/ofs_seq_ptr.sv
module ofs_seq_ptr
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  output ofs_sel_t sel
);
  ofs_sel_t sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= SEL_EMPTY_LO;
    else if (step) sel_q <= ofs_sel_t'(sel_q + 2'd1);
  end

  assign sel = sel_q;
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  ofs_sel_t                     wsel,
  input  logic [DW-1:0]                wdata,
  output logic [NUM_REGS-1:0][DW-1:0]  regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = DW'(reg_mask(DEPTH, g));
    localparam logic [DW-1:0] INIT = DW'(reg_init(DEPTH, g));
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= INIT;
      else if (we && wsel == ofs_sel_t'(g)) q <= wdata & MASK;
    end

    assign regs[g] = q;
  end
endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 9,
  localparam int OW   = ofs_width(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [DW-1:0] din,
  output logic          ld_mode,
  output logic          fifo_wr,
  output logic          fifo_rd,
  output logic [DW-1:0] rb_data,
  output logic          rb_valid,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs
);
  // named internal events, observed by the bound checker
  logic                        wr_evt;
  logic                        rd_evt;
  ofs_sel_t                    wr_ptr;
  ofs_sel_t                    rd_ptr;
  logic [NUM_REGS-1:0][DW-1:0] regs;
  logic [DW-1:0]               rb_q;
  logic                        rb_v;

  ofs_access_decode u_dec (
    .wr_clk     (wr_clk),
    .rst_n      (rst_n),
    .wen1_n     (wen1_n),
    .wen2_ld    (wen2_ld),
    .ren1_n     (ren1_n),
    .ren2_n     (ren2_n),
    .ld_mode    (ld_mode),
    .ofs_wr_evt (wr_evt),
    .ofs_rd_evt (rd_evt),
    .fifo_wr    (fifo_wr),
    .fifo_rd    (fifo_rd)
  );

  ofs_seq_ptr u_wptr (.clk(wr_clk), .rst_n(rst_n), .step(wr_evt), .sel(wr_ptr));
  ofs_seq_ptr u_rptr (.clk(rd_clk), .rst_n(rst_n), .step(rd_evt), .sel(rd_ptr));

  ofs_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .we    (wr_evt),
    .wsel  (wr_ptr),
    .wdata (din),
    .regs  (regs)
  );

  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      rb_q <= '0;
      rb_v <= 1'b0;
    end else begin
      rb_v <= rd_evt;
      if (rd_evt) rb_q <= regs[rd_ptr];
    end
  end

  assign rb_data   = rb_q;
  assign rb_valid  = rb_v;
  assign empty_ofs = OW'(join_ofs(int'(regs[SEL_EMPTY_LO]), int'(regs[SEL_EMPTY_HI])));
  assign full_ofs  = OW'(join_ofs(int'(regs[SEL_FULL_LO]),  int'(regs[SEL_FULL_HI])));
endmodule

// File: rtl/flag_offset_regs_chk.sv
module flag_offset_regs_chk
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 9,
  parameter int OW    = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          ld_mode,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic [1:0]    wr_ptr,
  input logic [1:0]    rd_ptr,
  input logic [DW-1:0] rb_data,
  input logic          rb_valid,
  input logic [OW-1:0] empty_ofs,
  input logic [OW-1:0] full_ofs
);
  localparam logic [DW-1:0] KEEP = DW'(reg_mask(DEPTH, 0) | reg_mask(DEPTH, 1));
  localparam logic [OW-1:0] DEF  = OW'(reg_init(DEPTH, 0));

  // R1
  reset_default_chk: assert property (@(posedge wr_clk)
    !rst_n |=> (empty_ofs == DEF && full_ofs == DEF && wr_ptr == 2'd0));

  // R3
  wr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_evt |=> wr_ptr == 2'($past(wr_ptr) + 2'd1));

  // R4
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_evt |=> $stable(wr_ptr) && $stable(empty_ofs) && $stable(full_ofs));

  // R5
  rb_pulse_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_evt |=> rb_valid && rd_ptr == 2'($past(rd_ptr) + 2'd1));

  // R6
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_evt |=> !rb_valid && $stable(rb_data) && $stable(rd_ptr));

  // R7
  unused_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rb_data & ~KEEP) == '0);

  // R10
  two_enable_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !ld_mode |-> !wr_evt && !rd_evt);
endmodule

bind flag_offset_regs flag_offset_regs_chk #(.DEPTH(DEPTH), .DW(DW), .OW(OW)) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst_n     (rst_n),
  .ld_mode   (ld_mode),
  .wr_evt    (wr_evt),
  .rd_evt    (rd_evt),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .rb_data   (rb_data),
  .rb_valid  (rb_valid),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs)
);

// File: tb/sim_flag_offset_regs.sv
module sim_flag_offset_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wen1_n = 1'b1, wen2_ld = 1'b0, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [8:0] din = '0;
  logic       ld_mode, fifo_wr, fifo_rd, rb_valid;
  logic [8:0] rb_data;
  logic [9:0] empty_ofs, full_ofs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  flag_offset_regs u0 (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .din(din), .ld_mode(ld_mode), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .rb_data(rb_data), .rb_valid(rb_valid),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  // behavioural reference model
  int m_reg[4];
  int m_wp, m_rp, m_rb, m_rbv;
  bit m_mode;

  function automatic int keep(input int idx, input int v);
    return (idx == 0 || idx == 2) ? (v % 256) : (v % 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = '{7, 0, 7, 0};
      m_wp = 0; m_rp = 0; m_rb = 0; m_rbv = 0;
      m_mode = !wen2_ld;
    end else begin
      m_rbv = 0;
      if (m_mode && !wen2_ld && !ren1_n && !ren2_n) begin
        m_rb = m_reg[m_rp];
        m_rbv = 1;
        m_rp = (m_rp + 1) % 4;
      end
      if (m_mode && !wen2_ld && !wen1_n) begin
        m_reg[m_wp] = keep(m_wp, int'(din));
        m_wp = (m_wp + 1) % 4;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R8 empty_ofs", int'(empty_ofs), m_reg[1] * 256 + m_reg[0]);
      chk("R8 full_ofs",  int'(full_ofs),  m_reg[3] * 256 + m_reg[2]);
      chk("R5 rb_data",   int'(rb_data),   m_rb);
      chk("R5 rb_valid",  int'(rb_valid),  m_rbv);
      chk("R2 ld_mode",   int'(ld_mode),   int'(m_mode));
      chk("R9 fifo_wr", int'(fifo_wr), int'(rst_n && !wen1_n && wen2_ld));
      chk("R9 fifo_rd", int'(fifo_rd),
          int'(rst_n && !ren1_n && !ren2_n && (!m_mode || wen2_ld)));
    end
  end

  task automatic cyc(input logic w1, input logic w2, input logic r1, input logic r2,
                     input logic [8:0] d);
    wen1_n = w1; wen2_ld = w2; ren1_n = r1; ren2_n = r2; din = d;
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, pin, 1'b1, 1'b1, 9'h000);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // load mode
    do_reset(1'b0);
    chk("R1 empty default", int'(empty_ofs), 7);
    chk("R1 full default",  int'(full_ofs), 7);
    chk("R1 rb_data reset", int'(rb_data), 0);
    chk("R2 load mode",     int'(ld_mode), 1);

    // read defaults
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R5 first readback", int'(rb_data), 7);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R5 last readback", int'(rb_data), 0);

    // load with a no-op in between
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'h1A5);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 9'h155);
    chk("R4 no-op keeps empty_ofs", int'(empty_ofs), 9'h0A5);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'h1FF);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'h13C);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'h002);
    chk("R8 empty assembled", int'(empty_ofs), 10'h3A5);
    chk("R8 full assembled",  int'(full_ofs),  10'h23C);

    // FIFO traffic with load pin high, then readback with a no-op
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 9'h0FF);
    chk("R9 ordinary write leaves offsets", int'(empty_ofs), 10'h3A5);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R7 low bit 8 dropped", int'(rb_data), 9'h0A5);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 9'h000);
    chk("R6 no-op read holds", int'(rb_data), 9'h0A5);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R7 high bits 8:2 dropped", int'(rb_data), 9'h003);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 9'h000);
    chk("R6 FIFO read holds rb_data", int'(rb_data), 9'h003);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R5 full high readback", int'(rb_data), 9'h002);

    // write pointer wrapped to empty-low
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'h011);
    chk("R3 wrap to first register", int'(empty_ofs), 10'h311);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h000);
    chk("R3 read pointer wrapped", int'(rb_data), 9'h011);

    // mixed strobe patterns
    for (int i = 0; i < 16; i++)
      cyc(logic'(i[0]), logic'(i[1]), logic'(i[2]), logic'(i[3]), 9'(i * 37));

    // two-enable mode
    do_reset(1'b1);
    chk("R2 two-enable mode", int'(ld_mode), 0);
    for (int i = 0; i < 16; i++)
      cyc(logic'(i[0]), logic'(i[1]), logic'(i[2]), logic'(i[3]), 9'h1F0);
    chk("R10 empty untouched", int'(empty_ofs), 7);
    chk("R10 full untouched",  int'(full_ofs), 7);
    chk("R10 no readback",     int'(rb_valid), 0);

    cyc(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule